// File: doc/BRIEF.md
# Interrupt Steering Controller

This block gathers a set of interrupt request lines and lets software send each one to any of five processor targets, at one of three priority levels. Internal requests come from logic in the same clock domain. External requests arrive asynchronously and pass through a synchroniser first. Only a rising edge of a request matters. It sets a bit in the status register of the processor and level that the request's routing field selects. That bit stays set until software writes a one to it. A temperature or voltage alert wired to one of these inputs is therefore held until it is cleared.

Each processor has one status, one mask and one pending register per level. A pending bit is the status bit gated by its mask bit. Each processor has two outputs. The urgent output is the OR of all level-one pending bits. The second output is the OR of the level-two and level-three pending bits.

Software reaches the block through a plain synchronous register port: address, write data, write enable and a combinational read data bus. There is no streaming data path, so no valid/ready handshake is used, and a write takes effect at the clock edge on which the write enable is sampled high.

Top module: `irq_steer`

## Requirements
- R1: After reset, every routing register reads 0x07 (no target), every status, mask and pending register reads zero, and both output vectors are low.
- R2: External request j (source bit 8+j) sets its status bit on the third rising clock edge after it rises. The bit stays set after the request falls.
- R3: Internal request i (source bit i, 0 to 7) sets its status bit on the first rising clock edge at which it is seen high after having been low.
- R4: Source s has a routing register at address s. Bits [2:0] select the processor: codes 0 to 4 are processors 0 to 4, and codes 5 to 7 select none. Bits [4:3] select the level: codes 0, 1 and 2 are levels one, two and three, and code 3 selects none. A source routed to none sets no status bit.
- R5: The status register of processor p, level code l, is at address 0x40+4p+l. Writing a one clears that bit and writing a zero leaves it unchanged.
- R6: The mask register of processor p, level code l, is at address 0x60+4p+l and is read/write. A one enables the source, and a change to the mask updates the outputs from the edge of the write.
- R7: The pending register at address 0x80+4p+l reads as status AND mask. Writes to it have no effect.
- R8: Output irq_urgent[p] is the OR of the level-one pending bits of processor p. Output irq_normal[p] is the OR of its level-two and level-three pending bits.
- R9: When a request edge and a clearing write hit the same status bit on the same edge, the bit stays set.
- R10: A request held high sets its bit only once. After a clear, the bit stays clear until the request falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 24 | Asynchronous external request lines |
| int_req | input | 8 | Synchronous internal request lines |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_urgent | output | 5 | Per-processor level-one interrupt |
| irq_normal | output | 5 | Per-processor level-two/three interrupt |

## Verification
An external request sets its status bit three edges after it is raised, so the bench checks the outputs once after the second edge, where they must still be low, and again after the third. Internal requests, clearing writes and mask writes all act on the first edge. Their results are sampled at the falling edge that follows. Reads are combinational, so they are sampled a short delay after the address is applied in the low half of the clock. The sweep covers every source with every routing code, including the codes that select no target. Further directed cases cover masking, read-only pending registers, a request that coincides with a clear, and a request held high across a clear.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int PROC_W  = 3;
  localparam int LVL_W   = 2;
  localparam int ROUTE_W = PROC_W + LVL_W;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic [PROC_W-1:0] proc;
  } route_t;

  localparam route_t ROUTE_NONE = '{lvl: 2'd0, proc: 3'd7};

  localparam int BASE_STAT = 'h40;
  localparam int BASE_MASK = 'h60;
  localparam int BASE_PEND = 'h80;
endpackage

// File: rtl/irq_steer_edge.sv
module irq_steer_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] samp;
  logic [W-1:0] prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign samp = din;
    end else begin : g_sync
      logic [W-1:0] chain_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
          chain_q[0] <= din;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign samp = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= samp;
  end

  assign rise = samp & ~prev_q;

  // R10: a level held high yields a single edge pulse
  assert_single_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_PROC = 5,
  parameter int N_LVL  = 3,
  localparam int N_BANK = N_PROC * N_LVL
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_SRC-1:0]                  rise,
  input  logic [N_SRC*ROUTE_W-1:0]          route_flat,
  output logic [N_BANK-1:0][N_SRC-1:0]      set_vec
);
  always_comb begin
    int pr;
    int lv;
    set_vec = '0;
    for (int s = 0; s < N_SRC; s++) begin
      pr = int'(route_flat[s*ROUTE_W +: PROC_W]);
      lv = int'(route_flat[s*ROUTE_W+PROC_W +: LVL_W]);
      if (rise[s] && pr < N_PROC && lv < N_LVL)
        set_vec[pr*N_LVL+lv][s] = 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_col
      logic [N_BANK-1:0] col;
      for (genvar k = 0; k < N_BANK; k++) begin : g_bit
        assign col[k] = set_vec[k][s];
      end
      // R4: a source event reaches at most one processor and level
      assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col));
    end
  endgenerate
endmodule

// File: rtl/irq_steer_bank.sv
module irq_steer_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_bits,
  input  logic [N_SRC-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] pending,
  output logic             any_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_bits) | set_bits;
      if (mask_we) mask <= mask_wdata;
    end
  end

  assign pending  = status & mask;
  assign any_pend = |pending;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((status & $past(set_bits)) == $past(set_bits)));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_bits & ~set_bits) != '0) |=> ((status & $past(clr_bits & ~set_bits)) == '0));
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask));
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int N_INT      = 8,
  parameter int N_EXT      = 24,
  parameter int N_PROC     = 5,
  parameter int N_LVL      = 3,
  parameter int SYNC_DEPTH = 2,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic [N_INT-1:0]  int_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PROC-1:0] irq_urgent,
  output logic [N_PROC-1:0] irq_normal
);
  localparam int N_SRC  = N_INT + N_EXT;
  localparam int N_BANK = N_PROC * N_LVL;
  localparam int STRIDE = 1 << $clog2(N_LVL);

  logic [N_INT-1:0]               rise_int;
  logic [N_EXT-1:0]               rise_ext;
  logic [N_SRC-1:0]               rise_all;
  route_t                         route_q [N_SRC];
  logic [N_SRC*ROUTE_W-1:0]       route_flat;
  logic [N_BANK-1:0][N_SRC-1:0]   set_vec;
  logic [N_SRC-1:0]               status_a  [N_BANK];
  logic [N_SRC-1:0]               mask_a    [N_BANK];
  logic [N_SRC-1:0]               pending_a [N_BANK];
  logic [N_BANK-1:0]              any_a;

  irq_steer_edge #(.W(N_INT), .STAGES(0)) u_int_edge (
    .clk(clk), .rst_n(rst_n), .din(int_req), .rise(rise_int));
  irq_steer_edge #(.W(N_EXT), .STAGES(SYNC_DEPTH)) u_ext_edge (
    .clk(clk), .rst_n(rst_n), .din(ext_req), .rise(rise_ext));

  assign rise_all = {rise_ext, rise_int};

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_route
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          route_q[s] <= ROUTE_NONE;
        else if (bus_we && int'(bus_addr) == s)
          route_q[s] <= route_t'(bus_wdata[ROUTE_W-1:0]);
      end
      assign route_flat[s*ROUTE_W +: ROUTE_W] = route_q[s];
    end
  endgenerate

  irq_steer_decode #(.N_SRC(N_SRC), .N_PROC(N_PROC), .N_LVL(N_LVL)) u_decode (
    .clk(clk), .rst_n(rst_n), .rise(rise_all), .route_flat(route_flat),
    .set_vec(set_vec));

  generate
    for (genvar p = 0; p < N_PROC; p++) begin : g_proc
      for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        localparam int K = p * N_LVL + l;
        logic [N_SRC-1:0] clr_bits;
        logic             mask_we;
        assign clr_bits = (bus_we && int'(bus_addr) == BASE_STAT + p*STRIDE + l)
                          ? bus_wdata[N_SRC-1:0] : '0;
        assign mask_we  = bus_we && int'(bus_addr) == BASE_MASK + p*STRIDE + l;
        irq_steer_bank #(.N_SRC(N_SRC)) u_bank (
          .clk(clk), .rst_n(rst_n),
          .set_bits(set_vec[K]), .clr_bits(clr_bits),
          .mask_we(mask_we), .mask_wdata(bus_wdata[N_SRC-1:0]),
          .status(status_a[K]), .mask(mask_a[K]), .pending(pending_a[K]),
          .any_pend(any_a[K]));
      end

      // R8: an asserted output is backed by a set status bit of that processor
      assert_out_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_urgent[p] || irq_normal[p]) |->
          ((status_a[p*N_LVL] | status_a[p*N_LVL+N_LVL-1]
            | status_a[p*N_LVL+(N_LVL>2 ? 1 : 0)]) != '0));
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < N_PROC; p++) begin
      irq_urgent[p] = any_a[p*N_LVL];
      irq_normal[p] = 1'b0;
      for (int l = 1; l < N_LVL; l++) irq_normal[p] = irq_normal[p] | any_a[p*N_LVL+l];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < N_SRC; s++)
      if (int'(bus_addr) == s) bus_rdata[ROUTE_W-1:0] = route_q[s];
    for (int p = 0; p < N_PROC; p++) begin
      for (int l = 0; l < N_LVL; l++) begin
        if (int'(bus_addr) == BASE_STAT + p*STRIDE + l) bus_rdata[N_SRC-1:0] = status_a[p*N_LVL+l];
        if (int'(bus_addr) == BASE_MASK + p*STRIDE + l) bus_rdata[N_SRC-1:0] = mask_a[p*N_LVL+l];
        if (int'(bus_addr) == BASE_PEND + p*STRIDE + l) bus_rdata[N_SRC-1:0] = pending_a[p*N_LVL+l];
      end
    end
  end

  // R4: routing registers change only on a bus write
  assert_route_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(route_flat));
endmodule

// File: tb/test_irq_steer.sv
module test_irq_steer;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] ext_req = '0;
  logic [7:0]  int_req = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [4:0]  irq_urgent;
  logic [4:0]  irq_normal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer i_irq_steer (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .irq_urgent(irq_urgent), .irq_normal(irq_normal));

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = 8'(addr); bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] data);
    bus_addr = 8'(addr);
    #1;
    data = bus_rdata;
  endtask

  task automatic set_src(input int s, input logic v);
    if (s < 8) int_req[s] = v;
    else       ext_req[s-8] = v;
  endtask

  function automatic int stat_addr(input int p, input int l); return 'h40 + 4*p + l; endfunction
  function automatic int mask_addr(input int p, input int l); return 'h60 + 4*p + l; endfunction
  function automatic int pend_addr(input int p, input int l); return 'h80 + 4*p + l; endfunction

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [4:0]  exp_u, exp_n;
    bit          valid;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_eq("R1 outputs", {22'd0, irq_urgent, irq_normal}, 32'd0);
    for (int s = 0; s < 32; s += 7) begin
      bus_read(s, rd); check_eq("R1 route", rd, 32'h7);
    end
    for (int p = 0; p < 5; p++) begin
      for (int l = 0; l < 3; l++) begin
        bus_read(stat_addr(p, l), rd); check_eq("R1 status", rd, 32'd0);
        bus_read(mask_addr(p, l), rd); check_eq("R1 mask", rd, 32'd0);
      end
    end

    // R6: masks are read/write; enable everything for the sweep
    for (int p = 0; p < 5; p++)
      for (int l = 0; l < 3; l++) bus_write(mask_addr(p, l), 32'hFFFF_FFFF);
    @(negedge clk);
    bus_read(mask_addr(4, 2), rd); check_eq("R6 mask readback", rd, 32'hFFFF_FFFF);

    // R2 R3 R4 R8 R5: sweep every source over every routing code
    for (int s = 0; s < 32; s++) begin
      for (int pc = 0; pc < 8; pc++) begin
        for (int lc = 0; lc < 4; lc++) begin
          bus_write(s, 32'(lc*8 + pc));
          bus_read(s, rd); check_eq("R4 route readback", rd, 32'(lc*8 + pc));
          valid = (pc < 5) && (lc < 3);
          exp_u = (valid && lc == 0) ? 5'(1 << pc) : 5'd0;
          exp_n = (valid && lc != 0) ? 5'(1 << pc) : 5'd0;
          set_src(s, 1'b1);
          if (s >= 8) begin
            repeat (2) @(negedge clk);
            check_eq("R2 not early", {22'd0, irq_urgent, irq_normal}, 32'd0);
          end
          @(negedge clk);
          check_eq(s < 8 ? "R3 R8 urgent" : "R2 R8 urgent", {27'd0, irq_urgent}, {27'd0, exp_u});
          check_eq(s < 8 ? "R3 R8 normal" : "R2 R8 normal", {27'd0, irq_normal}, {27'd0, exp_n});
          set_src(s, 1'b0);
          @(negedge clk);
          if (valid) begin
            bus_read(stat_addr(pc, lc), rd);
            check_eq("R2 latched status", rd, 32'(1) << s);
            bus_write(stat_addr(pc, lc), 32'(1) << s);
            check_eq("R5 cleared outputs", {22'd0, irq_urgent, irq_normal}, 32'd0);
          end
          repeat (2) @(negedge clk);
        end
      end
    end

    // R6 R7: masking and read-only pending, source 9 (external 1) to proc 2 level code 1
    bus_write(mask_addr(2, 1), 32'd0);
    bus_write(9, 32'(1*8 + 2));
    set_src(9, 1'b1);
    repeat (3) @(negedge clk);
    set_src(9, 1'b0);
    check_eq("R6 masked output", {27'd0, irq_normal}, 32'd0);
    bus_read(stat_addr(2, 1), rd); check_eq("R6 status under mask", rd, 32'h200);
    bus_read(pend_addr(2, 1), rd); check_eq("R7 pending masked", rd, 32'd0);
    bus_write(mask_addr(2, 1), 32'h200);
    check_eq("R6 unmask output", {27'd0, irq_normal}, 32'h4);
    bus_read(pend_addr(2, 1), rd); check_eq("R7 pending", rd, 32'h200);
    bus_write(pend_addr(2, 1), 32'h0);
    bus_read(pend_addr(2, 1), rd); check_eq("R7 pending write ignored", rd, 32'h200);
    bus_read(stat_addr(2, 1), rd); check_eq("R7 status untouched", rd, 32'h200);
    // R5: writing zero to status keeps the bit
    bus_write(stat_addr(2, 1), 32'h0);
    bus_read(stat_addr(2, 1), rd); check_eq("R5 zero write keeps", rd, 32'h200);
    bus_write(stat_addr(2, 1), 32'h200);
    bus_read(stat_addr(2, 1), rd); check_eq("R5 one write clears", rd, 32'd0);

    // R9: request edge and clear on the same edge, source 0 to proc 1 level code 0
    bus_write(0, 32'(0*8 + 1));
    set_src(0, 1'b1);
    @(negedge clk);
    set_src(0, 1'b0);
    @(negedge clk);
    bus_read(stat_addr(1, 0), rd); check_eq("R9 first set", rd, 32'h1);
    bus_addr = 8'(stat_addr(1, 0)); bus_wdata = 32'h1; bus_we = 1'b1;
    set_src(0, 1'b1);
    @(negedge clk);
    bus_we = 1'b0;
    bus_read(stat_addr(1, 0), rd); check_eq("R9 set wins", rd, 32'h1);
    check_eq("R9 output held", {27'd0, irq_urgent}, 32'h2);

    // R10: request stays high across a clear
    bus_write(stat_addr(1, 0), 32'h1);
    repeat (3) @(negedge clk);
    bus_read(stat_addr(1, 0), rd); check_eq("R10 no re-set while high", rd, 32'd0);
    check_eq("R10 output low", {27'd0, irq_urgent}, 32'd0);
    set_src(0, 1'b0);
    @(negedge clk);
    set_src(0, 1'b1);
    @(negedge clk);
    bus_read(stat_addr(1, 0), rd); check_eq("R10 new edge sets", rd, 32'h1);
    set_src(0, 1'b0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule